// File: doc/BRIEF.md
# Xoff Retransmission Scheduler

This block works next to a UART that uses in-band software flow control. Once the local receiver has told the far end to pause, it is in the XOFF state. The remote side may not notice that request and can keep sending. While the XOFF state holds, the scheduler counts each character the receiver delivers. Whenever the count reaches a programmable period, the scheduler raises a request asking the transmitter to send the Xoff character again. The transmitter is expected to send that character ahead of any data it already has queued.

The period is 1, 4, 8 or 16 received characters, chosen by a 2-bit select held in a small configuration register. Retransmission needs two enables at the same time: the software flow-control enable and a separate retransmit enable. The request leaves the block on a valid/ready stream whose payload is the programmed Xoff code. A request stays pending until the transmitter accepts it. Further period hits that arrive while a request is pending merge into that one request; they do not queue.

Top module: `xoff_resend_sched`

## Requirements
- R1: `req_valid` can be high only in a cycle after an edge at which `fc_en` and `resend_en` were both high. If either enable is low at an edge, any pending request is dropped at that edge.
- R2: The select in `cfg_rdata[1:0]` sets the period: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 16 received characters. With the counter clear and no request pending, `req_valid` rises in the cycle after the edge that samples the period-th `rx_strobe`, and not before.
- R3: A synchronous active-high `rst` clears the select to 2'b00, the character counter and the pending request. After reset `req_valid` = 0 and `cfg_rdata` = 8'h00.
- R4: An `rx_strobe` counts only at an edge where `xoff_state` and both enables are high. Strobes at any other edge leave the count unchanged and raise no request.
- R5: A write (`cfg_we` = 1) loads `cfg_wdata[1:0]` into the select at that edge. `cfg_rdata[7:2]` always reads zero, whatever was written.
- R6: The counter returns to zero at every edge where `xoff_state` or either enable is low. A count interrupted by leaving the XOFF state, or by dropping an enable, starts again from zero.
- R7: Once raised, `req_valid` stays high until an edge with `req_ready` high (R1 excepted). Such an accepting edge clears the request, unless a new period hit happens at the same edge; in that case `req_valid` stays high.
- R8: Period hits that occur while a request is pending merge into it. After one accepting edge with no new hit, `req_valid` is low.
- R9: `req_data` always equals `xoff_code`.
- R10: A new select takes effect on the current count at once. If the count already equals or exceeds the new period, the next counted character raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fc_en | input | 1 | Software flow-control enable |
| resend_en | input | 1 | Xoff retransmit enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data; bits 1:0 are the period select |
| cfg_rdata | output | 8 | Configuration readback; bits 7:2 are zero |
| xoff_state | input | 1 | High while the local receiver holds the remote end in XOFF |
| rx_strobe | input | 1 | One-cycle pulse per received character |
| xoff_code | input | 8 | Xoff character code to be sent |
| req_valid | output | 1 | Retransmit request pending |
| req_ready | input | 1 | Transmitter accepts the request |
| req_data | output | 8 | Character to transmit (the Xoff code) |

## Verification
The checker treats `rx_strobe` as at most one pulse per cycle. It also assumes that `xoff_code` does not change while a request is pending. For that reason it checks that `req_valid` is held, not that the payload is stable. The period checks assume the select, enables and XOFF flag stay constant during each counting run. The stimulus drives every input on the falling edge, changes configuration only between runs (the R10 case excepted), and clears the counter by leaving the XOFF state between sweep steps.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  localparam int SEL_W    = 2;
  localparam int MAX_PER  = 16;
  localparam int CNT_W    = $clog2(MAX_PER);
  localparam int PER_W    = CNT_W + 1;

  typedef enum logic [SEL_W-1:0] {
    PER_1  = 2'b00,
    PER_4  = 2'b01,
    PER_8  = 2'b10,
    PER_16 = 2'b11
  } period_sel_e;

  function automatic logic [PER_W-1:0] period_of(input period_sel_e s);
    case (s)
      PER_1:   period_of = PER_W'(1);
      PER_4:   period_of = PER_W'(4);
      PER_8:   period_of = PER_W'(8);
      default: period_of = PER_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/xrs_cfg_reg.sv
module xrs_cfg_reg
  import xrs_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output period_sel_e      sel
);
  localparam int PAD_W = REG_W - SEL_W;

  always_ff @(posedge clk) begin
    if (rst)     sel <= PER_1;
    else if (we) sel <= period_sel_e'(wdata[SEL_W-1:0]);
  end

  assign rdata = {{PAD_W{1'b0}}, sel};
endmodule

// File: rtl/xrs_char_counter.sv
module xrs_char_counter
  import xrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             strobe,
  input  logic [PER_W-1:0] period,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] cnt_next;

  assign cnt_next = PER_W'(cnt) + PER_W'(1);
  assign hit      = active && strobe && (cnt_next >= period);

  always_ff @(posedge clk) begin
    if (rst || !active)   cnt <= '0;
    else if (hit)         cnt <= '0;
    else if (strobe)      cnt <= cnt_next[CNT_W-1:0];
  end
endmodule

// File: rtl/xrs_req_hold.sv
module xrs_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic allow,
  input  logic hit,
  input  logic ready,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst || !allow) pending <= 1'b0;
    else if (hit)      pending <= 1'b1;
    else if (ready)    pending <= 1'b0;
  end
endmodule

// File: rtl/xoff_resend_sched.sv
module xoff_resend_sched
  import xrs_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fc_en,
  input  logic              resend_en,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              xoff_state,
  input  logic              rx_strobe,
  input  logic [CHAR_W-1:0] xoff_code,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CHAR_W-1:0] req_data
);
  period_sel_e      sel;
  logic [PER_W-1:0] period;
  logic             allow;
  logic             counting;
  logic             hit;

  assign allow    = fc_en && resend_en;
  assign counting = allow && xoff_state;
  assign period   = period_of(sel);

  xrs_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .sel(sel)
  );

  xrs_char_counter u_cnt (
    .clk(clk), .rst(rst), .active(counting), .strobe(rx_strobe),
    .period(period), .hit(hit)
  );

  xrs_req_hold u_req (
    .clk(clk), .rst(rst), .allow(allow), .hit(hit),
    .ready(req_ready), .pending(req_valid)
  );

  assign req_data = xoff_code;
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker #(
  parameter int CHAR_W = 8,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fc_en,
  input logic              resend_en,
  input logic              cfg_we,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              xoff_state,
  input logic              rx_strobe,
  input logic [CHAR_W-1:0] xoff_code,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CHAR_W-1:0] req_data
);
  assert_gated_by_enables_R1: assert property (@(posedge clk) disable iff (rst)
    !(fc_en && resend_en) |=> !req_valid);

  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> (!req_valid && cfg_rdata == '0));

  assert_rise_needs_counted_char_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(rx_strobe && xoff_state && fc_en && resend_en));

  assert_select_loaded_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata[1:0] == $past(cfg_wdata[1:0]));

  assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && fc_en && resend_en) |=> req_valid);

  always_comb begin
    if (!rst) begin
      assert_upper_zero_R5: assert (cfg_rdata[REG_W-1:2] == '0);
      assert_payload_R9:    assert (req_data == xoff_code);
    end
  end
endmodule

bind xoff_resend_sched xrs_checker #(.CHAR_W(CHAR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .fc_en(fc_en), .resend_en(resend_en),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .xoff_state(xoff_state), .rx_strobe(rx_strobe), .xoff_code(xoff_code),
  .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data)
);

// File: tb/sim_xoff_resend_sched.sv
module sim_xoff_resend_sched;
  logic       clk = 1'b0;
  logic       rst, fc_en, resend_en, cfg_we, xoff_state, rx_strobe, req_ready;
  logic [7:0] cfg_wdata, cfg_rdata, xoff_code, req_data;
  logic       req_valid;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #5 clk = ~clk;

  xoff_resend_sched u0 (
    .clk(clk), .rst(rst), .fc_en(fc_en), .resend_en(resend_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xoff_state(xoff_state), .rx_strobe(rx_strobe), .xoff_code(xoff_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe();
    rx_strobe = 1'b1; tick(); rx_strobe = 1'b0;
  endtask

  task automatic wr_sel(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
  endtask

  task automatic ack();
    req_ready = 1'b1; tick(); req_ready = 1'b0;
  endtask

  task automatic restart();
    xoff_state = 1'b0; tick(); xoff_state = 1'b1;
  endtask

  function automatic int per_of(input int s);
    return (s == 0) ? 1 : (1 << (s + 1));
  endfunction

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; fc_en = 1'b0; resend_en = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    xoff_state = 1'b0; rx_strobe = 1'b0; req_ready = 1'b0; xoff_code = 8'h13;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R3: reset state
    chk("R3 valid", req_valid, 0);
    chk("R3 rdata", cfg_rdata, 0);

    // R5: only the select bits are stored and read back
    for (int v = 0; v < 256; v += 17) begin
      wr_sel(8'(v));
      chk("R5 rdata", cfg_rdata, v & 3);
    end

    fc_en = 1'b1; resend_en = 1'b1;
    // R2 / R9: sweep every select with several payloads
    for (int s = 0; s < 4; s++) begin
      wr_sel(8'(s | 8'hFC));
      xoff_code = 8'(8'h11 + s * 8'h22);
      restart();
      for (int i = 1; i <= per_of(s); i++) begin
        strobe();
        chk("R2 period", req_valid, (i == per_of(s)) ? 1 : 0);
      end
      chk("R9 payload", req_data, 8'(8'h11 + s * 8'h22));
      ack();
      chk("R7 ack clears", req_valid, 0);
    end

    // R4: strobes outside XOFF state are not counted
    wr_sel(8'h01); xoff_state = 1'b0;
    for (int i = 0; i < 20; i++) strobe();
    chk("R4 outside xoff", req_valid, 0);
    xoff_state = 1'b1;
    for (int i = 0; i < 3; i++) strobe();
    chk("R4 count from zero", req_valid, 0);
    strobe();
    chk("R4 fourth char", req_valid, 1);
    ack();

    // R1: every enable combination, period 1
    wr_sel(8'h00);
    for (int e = 0; e < 4; e++) begin
      fc_en = e[0]; resend_en = e[1];
      restart();
      strobe(); strobe();
      chk("R1 enables", req_valid, (e == 3) ? 1 : 0);
      req_ready = 1'b1; tick(); req_ready = 1'b0;
    end
    // R1: dropping an enable removes a pending request
    strobe();
    chk("R1 pending", req_valid, 1);
    resend_en = 1'b0; tick(); resend_en = 1'b1;
    chk("R1 dropped", req_valid, 0);

    // R6: leaving XOFF clears the partial count
    wr_sel(8'h01); restart();
    for (int i = 0; i < 3; i++) strobe();
    restart();
    for (int i = 0; i < 3; i++) strobe();
    chk("R6 xoff toggle", req_valid, 0);
    strobe();
    chk("R6 xoff toggle hit", req_valid, 1);
    ack();
    // R6: dropping an enable clears the partial count
    for (int i = 0; i < 3; i++) strobe();
    fc_en = 1'b0; tick(); fc_en = 1'b1;
    for (int i = 0; i < 3; i++) strobe();
    chk("R6 enable drop", req_valid, 0);
    strobe();
    chk("R6 enable drop hit", req_valid, 1);

    // R7 / R8: held without ready, merged hits, single ack
    wr_sel(8'h00); restart(); ack();
    strobe();
    for (int i = 0; i < 5; i++) tick();
    chk("R7 held", req_valid, 1);
    strobe(); strobe();
    ack();
    chk("R8 merged", req_valid, 0);
    // R7: ack at the same edge as a new hit keeps the request
    strobe();
    rx_strobe = 1'b1; req_ready = 1'b1; tick(); rx_strobe = 1'b0; req_ready = 1'b0;
    chk("R7 ack with hit", req_valid, 1);
    ack();

    // R10: shrinking the period below the current count
    wr_sel(8'h03); restart();
    for (int i = 0; i < 6; i++) strobe();
    chk("R10 before change", req_valid, 0);
    wr_sel(8'h01);
    strobe();
    chk("R10 after change", req_valid, 1);
    ack();
    // R10: growing the period keeps the count
    wr_sel(8'h01); restart();
    for (int i = 0; i < 3; i++) strobe();
    wr_sel(8'h02);
    for (int i = 0; i < 4; i++) strobe();
    chk("R10 grow early", req_valid, 0);
    strobe();
    chk("R10 grow hit", req_valid, 1);

    // R3: reset mid-operation
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R3 valid mid", req_valid, 0);
    chk("R3 sel mid", cfg_rdata, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule